// File: doc/BRIEF.md
# ADC Offset and Gain Corrector

This block calibrates a stream of raw signed 16-bit ADC samples, one channel-tagged sample per clock. Each of 40 channels owns a signed offset and an unsigned gain coefficient held in an internal table. Each accepted sample is first shifted by its channel's offset and then scaled by its channel's gain. The gain is a fixed-point value in which 0x8000 stands for exactly one. The result is rounded, clamped to the signed 16-bit range and presented three clocks later, together with its channel index.

Software loads coefficients through a single-cycle write port. A select bit chooses between the offset and the gain of the addressed channel. Reset returns every channel to zero offset and unity gain, so an uncalibrated block passes samples through unchanged.

Top module: `adc_cal_corrector`

## Requirements
- R1: For an accepted sample x on channel c, the result is (x + offset[c]) * gain[c] / 32768, where offset is signed 16-bit and gain is unsigned 16-bit. A gain of 0 yields 0.
- R2: After reset every channel has offset 0 and gain 0x8000, so each output sample equals its input sample.
- R3: Rounding is to the nearest integer, and exact halves go away from zero (+50.5 gives 51, -50.5 gives -51).
- R4: Results above 32767 give 32767 and results below -32768 give -32768.
- R5: A sample presented with `smp_valid` high before clock edge k appears on `cal_valid`, `cal_ch` and `cal_sample` after edge k+2, which is three registers later. `cal_valid` is low in every other cycle.
- R6: A write with `coef_we` high and `coef_kind` = 0 loads the offset of channel `coef_ch`. With `coef_kind` = 1 it loads the gain. No other channel or coefficient changes.
- R7: A sample accepted on the same edge as a coefficient write uses the old coefficient. Samples accepted on later edges use the new one.
- R8: Writes to a channel index of 40 or above are ignored. Samples with such an index are corrected with offset 0 and gain 0x8000.
- R9: A reset issued after coefficients were written restores every channel to its defaults.
- R10: The offset sum is kept at 17 bits, so it does not wrap. For example, 32767 + 32767 at gain 0x4000 gives 32767, and -32768 + -32768 at gain 0x4000 gives -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_kind | input | 1 | 0 selects the offset, 1 selects the gain |
| coef_ch | input | 6 | Channel whose coefficient is written |
| coef_data | input | 16 | Coefficient value |
| smp_valid | input | 1 | Input sample qualifier |
| smp_ch | input | 6 | Channel index of the input sample |
| smp_data | input | 16 | Raw signed sample |
| cal_valid | output | 1 | Output sample qualifier |
| cal_ch | output | 6 | Channel index carried with the result |
| cal_sample | output | 16 | Corrected signed sample |

## Verification
The embedded properties assume that reset is held for at least one edge. They also assume that `smp_valid` and `coef_we` are never unknown, and the latency check starts only after three clean edges following reset. The bench holds both strobes low during reset. It drives every input half a period away from the sampling edge. It keeps random channel indices within 0..63, which covers both real and out-of-range channels. Random offsets and gains span their full codes, so the clamping and half-way rounding paths are reached alongside the directed corner values.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    localparam int NUM_CH   = 40;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 15;
    localparam int CH_W     = 6;
    localparam int SUM_W    = SAMPLE_W + 1;
    localparam int PROD_W   = SUM_W + COEF_W + 1;
    localparam logic [COEF_W-1:0] GAIN_UNITY = COEF_W'(1) << FRAC_W;

    typedef logic [CH_W-1:0]            ch_t;
    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   offset_t;
    typedef logic [COEF_W-1:0]          gain_t;
    typedef logic signed [SUM_W-1:0]    sum_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    typedef enum logic {KIND_OFFSET = 1'b0, KIND_GAIN = 1'b1} coef_kind_e;

    typedef struct packed {
        logic  valid;
        ch_t   ch;
        sum_t  sum;
        gain_t gain;
    } stage_sum_t;

    typedef struct packed {
        logic  valid;
        ch_t   ch;
        prod_t prod;
    } stage_prod_t;

    // Scale down by 2^FRAC_W, round half away from zero, clamp to sample range.
    function automatic sample_t round_sat(input prod_t p);
        logic [PROD_W-1:0] mag;
        logic [PROD_W-1:0] rmag;
        logic [PROD_W-1:0] neg_mag;
        sample_t           res;
        mag  = p[PROD_W-1] ? PROD_W'(-p) : PROD_W'(p);
        rmag = (mag + (PROD_W'(1) << (FRAC_W - 1))) >> FRAC_W;
        if (p[PROD_W-1]) begin
            neg_mag = PROD_W'(0) - rmag;
            res = (rmag > (PROD_W'(1) << (SAMPLE_W - 1))) ? sample_t'({1'b1, {(SAMPLE_W-1){1'b0}}})
                                                          : sample_t'(neg_mag[SAMPLE_W-1:0]);
        end else begin
            res = (rmag > ((PROD_W'(1) << (SAMPLE_W - 1)) - PROD_W'(1)))
                  ? sample_t'({1'b0, {(SAMPLE_W-1){1'b1}}}) : sample_t'(rmag[SAMPLE_W-1:0]);
        end
        return res;
    endfunction
endpackage

// File: rtl/cal_coef_table.sv
module cal_coef_table
    import adc_cal_pkg::*;
#(
    parameter int CHANNELS = NUM_CH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  logic    wr_kind,
    input  ch_t     wr_ch,
    input  gain_t   wr_data,
    input  ch_t     rd_ch,
    output offset_t rd_offset,
    output gain_t   rd_gain
);
    offset_t offset_q [CHANNELS];
    gain_t   gain_q   [CHANNELS];

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                offset_q[i] <= '0;
                gain_q[i]   <= GAIN_UNITY;
            end else if (wr_en && int'(wr_ch) == i) begin
                if (coef_kind_e'(wr_kind) == KIND_GAIN) gain_q[i] <= wr_data;
                else                                    offset_q[i] <= offset_t'(wr_data);
            end
        end
    end

    always_comb begin
        rd_offset = '0;
        rd_gain   = GAIN_UNITY;
        if (int'(rd_ch) < CHANNELS) begin
            rd_offset = offset_q[rd_ch];
            rd_gain   = gain_q[rd_ch];
        end
    end

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        $past(rst) |-> (rd_offset == '0 && rd_gain == GAIN_UNITY)); // R9
    AST_OOR_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_ch) >= CHANNELS) |-> (rd_offset == '0 && rd_gain == GAIN_UNITY)); // R8
endmodule

// File: rtl/cal_round_sat.sv
module cal_round_sat
    import adc_cal_pkg::*;
(
    input  prod_t   prod,
    output sample_t result
);
    always_comb result = round_sat(prod);
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
    import adc_cal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  ch_t     in_ch,
    input  sample_t in_sample,
    input  offset_t offset,
    input  gain_t   gain,
    output logic    out_valid,
    output ch_t     out_ch,
    output sample_t out_sample
);
    stage_sum_t  s_sum;
    stage_prod_t s_prod;
    sample_t     rs_value;
    prod_t       mul_a;
    prod_t       mul_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sum <= '0;
        end else begin
            s_sum.valid <= in_valid;
            s_sum.ch    <= in_ch;
            s_sum.sum   <= sum_t'(in_sample) + sum_t'(offset);
            s_sum.gain  <= gain;
        end
    end

    always_comb begin
        mul_a = prod_t'(s_sum.sum);
        mul_b = prod_t'({{(PROD_W-COEF_W){1'b0}}, s_sum.gain});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_prod <= '0;
        end else begin
            s_prod.valid <= s_sum.valid;
            s_prod.ch    <= s_sum.ch;
            s_prod.prod  <= mul_a * mul_b;
        end
    end

    cal_round_sat u_round (
        .prod   (s_prod.prod),
        .result (rs_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_ch     <= '0;
            out_sample <= '0;
        end else begin
            out_valid  <= s_prod.valid;
            out_ch     <= s_prod.ch;
            out_sample <= rs_value;
        end
    end

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
        (s_sum.valid && s_sum.gain == '0) |=> ##1 (out_sample == '0)); // R1
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (s_prod.valid && !s_prod.prod[PROD_W-1] && s_prod.prod >= (prod_t'(1) <<< (FRAC_W + SAMPLE_W - 1)))
        |=> (out_sample == 16'sh7fff)); // R4
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
        (s_prod.valid && s_prod.prod <= -(prod_t'(1) <<< (FRAC_W + SAMPLE_W - 1)))
        |=> (out_sample == -16'sh8000)); // R4
endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
    import adc_cal_pkg::*;
#(
    parameter int CHANNELS = NUM_CH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coef_we,
    input  logic                coef_kind,
    input  logic [CH_W-1:0]     coef_ch,
    input  logic [COEF_W-1:0]   coef_data,
    input  logic                smp_valid,
    input  logic [CH_W-1:0]     smp_ch,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                cal_valid,
    output logic [CH_W-1:0]     cal_ch,
    output logic [SAMPLE_W-1:0] cal_sample
);
    offset_t cur_offset;
    gain_t   cur_gain;
    sample_t res_sample;
    ch_t     res_ch;

    cal_coef_table #(.CHANNELS(CHANNELS)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (coef_we),
        .wr_kind   (coef_kind),
        .wr_ch     (coef_ch),
        .wr_data   (coef_data),
        .rd_ch     (smp_ch),
        .rd_offset (cur_offset),
        .rd_gain   (cur_gain)
    );

    cal_datapath u_path (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (smp_valid),
        .in_ch      (smp_ch),
        .in_sample  (sample_t'(smp_data)),
        .offset     (cur_offset),
        .gain       (cur_gain),
        .out_valid  (cal_valid),
        .out_ch     (res_ch),
        .out_sample (res_sample)
    );

    assign cal_ch     = res_ch;
    assign cal_sample = res_sample;

    // Edges seen since reset, saturating, so the latency checks never look into reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)               warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst || warm_q != 2'd3)
        cal_valid == $past(smp_valid, 3)); // R5
    AST_CH_CARRY: assert property (@(posedge clk) disable iff (rst || warm_q != 2'd3)
        cal_valid |-> (cal_ch == $past(smp_ch, 3))); // R5
endmodule

// File: tb/tb_adc_cal_corrector.sv
module tb_adc_cal_corrector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        coef_we, coef_kind;
    logic [5:0]  coef_ch;
    logic [15:0] coef_data;
    logic        smp_valid;
    logic [5:0]  smp_ch;
    logic [15:0] smp_data;
    logic        cal_valid;
    logic [5:0]  cal_ch;
    logic [15:0] cal_sample;

    adc_cal_corrector dut (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_kind(coef_kind),
        .coef_ch(coef_ch), .coef_data(coef_data), .smp_valid(smp_valid),
        .smp_ch(smp_ch), .smp_data(smp_data), .cal_valid(cal_valid),
        .cal_ch(cal_ch), .cal_sample(cal_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    int    m_off  [64];
    int    m_gain [64];
    bit    h_v    [3];
    int    h_ch   [3];
    int    h_x    [3];
    string h_tag  [3];

    function automatic int ref_cal(int x, int off, int g);
        longint p, m, r;
        p = longint'(x + off) * longint'(g);
        m = (p < 0) ? -p : p;
        r = (m + 16384) / 32768;
        if (p < 0) r = -r;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 64; i++) begin
            m_off[i]  = 0;
            m_gain[i] = 32768;
        end
    endtask

    task automatic check_out();
        n_checks++;
        if (h_v[2]) begin
            if (!cal_valid || int'(cal_ch) != h_ch[2] || int'($signed(cal_sample)) != h_x[2]) begin
                n_fail++;
                $display("FAIL %s: valid=%0b ch=%0d sample=%0d expected valid=1 ch=%0d sample=%0d",
                         h_tag[2], cal_valid, cal_ch, $signed(cal_sample), h_ch[2], h_x[2]);
            end
        end else if (cal_valid) begin
            n_fail++;
            $display("FAIL R5: valid=1 expected valid=0");
        end
    endtask

    // One clock: check output, drive inputs, advance bench history.
    task automatic step(input bit v, input int ch, input int x,
                        input bit we, input bit kind, input int wch, input int wdata,
                        input string tag);
        int exp_x;
        check_out();
        smp_valid = v; smp_ch = 6'(ch); smp_data = 16'(x);
        coef_we = we; coef_kind = kind; coef_ch = 6'(wch); coef_data = 16'(wdata);
        exp_x = ref_cal(x, m_off[ch], m_gain[ch]);
        if (we && wch < 40) begin
            if (kind) m_gain[wch] = wdata & 16'hffff;
            else      m_off[wch]  = int'($signed(16'(wdata)));
        end
        @(posedge clk);
        h_v[2] = h_v[1]; h_ch[2] = h_ch[1]; h_x[2] = h_x[1]; h_tag[2] = h_tag[1];
        h_v[1] = h_v[0]; h_ch[1] = h_ch[0]; h_x[1] = h_x[0]; h_tag[1] = h_tag[0];
        h_v[0] = v; h_ch[0] = ch; h_x[0] = exp_x; h_tag[0] = tag;
        @(negedge clk);
    endtask

    task automatic sample(input int ch, input int x, input string tag);
        step(1, ch, x, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit kind, input int ch, input int data, input string tag);
        step(0, 0, 0, 1, kind, ch, data, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R5");
    endtask

    task automatic do_reset();
        rst = 1;
        smp_valid = 0; coef_we = 0; coef_kind = 0; coef_ch = 0; coef_data = 0;
        smp_ch = 0; smp_data = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_defaults();
        for (int i = 0; i < 3; i++) begin
            h_v[i] = 0; h_ch[i] = 0; h_x[i] = 0; h_tag[i] = "R5";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset();
        // Reset state of outputs
        n_checks++;
        if (cal_valid !== 1'b0 || cal_sample !== 16'h0) begin
            n_fail++;
            $display("FAIL R2: valid=%0b sample=%0d expected valid=0 sample=0", cal_valid, cal_sample);
        end
        // R2 identity after reset
        sample(0, 1234, "R2");
        sample(39, -32768, "R2");
        sample(17, 32767, "R2");
        // R1 / R6 offset then gain
        wr(0, 5, 100, "R6");
        sample(5, 50, "R1");
        sample(6, 50, "R6");
        wr(1, 5, 16'h4000, "R6");
        sample(5, 1, "R3");
        sample(5, -201, "R3");
        wr(1, 11, 0, "R1");
        sample(11, -12345, "R1");
        // R4 clamp
        wr(1, 7, 16'hffff, "R4");
        sample(7, 30000, "R4");
        sample(7, -30000, "R4");
        // R10 17-bit sum
        wr(0, 8, 32767, "R10");
        wr(1, 8, 16'h4000, "R10");
        sample(8, 32767, "R10");
        wr(0, 8, 16'h8000, "R10");
        sample(8, -32768, "R10");
        // R7 same-edge write and sample
        step(1, 9, 1000, 1, 0, 9, 500, "R7");
        sample(9, 1000, "R7");
        // R8 out-of-range channel
        wr(0, 45, 777, "R8");
        wr(1, 63, 5, "R8");
        sample(45, 321, "R8");
        sample(63, -321, "R8");
        idle(3);
        // R5 / R1 random mix
        for (int i = 0; i < 3000; i++) begin
            bit v, we, kind;
            v    = ($urandom % 10) < 7;
            we   = ($urandom % 10) < 2;
            kind = $urandom % 2;
            step(v, $urandom % 64, int'($signed(16'($urandom))), we, kind,
                 $urandom % 64, $urandom & 16'hffff, "R1");
        end
        idle(3);
        // R9 reset restores defaults
        wr(0, 3, 2000, "R9");
        wr(1, 3, 16'h1000, "R9");
        idle(2);
        do_reset();
        sample(3, 4321, "R9");
        sample(5, -77, "R9");
        idle(3);
        check_out();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule